// File: doc/BRIEF.md
# Maskable-write GPIO data bank

This block is one bank of general-purpose pins, up to 32 wide, sitting behind a simple synchronous register bus. Its main feature is the pair of masked-write ports. Each port covers one 16-bit half of the output latch. Every written word carries a per-bit protect mask in its upper half and new output data in its lower half. Software can therefore flip one pin, or any subset of pins in a half, with a single store and no read-modify-write. This also makes the update atomic against other writers of the same bank.

Alongside the output latch the bank holds a direction register and an output-enable register. A pin is driven only when both of its bits are set. Pin levels come back through a read-only register after a two-flop synchronizer. Reads are combinational on the presented address. Writes take effect at the clock edge on which the write enable is sampled high.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset the output latch, the direction register and the output-enable register are all zero, so `pin_out` and `pin_oe` are zero.
- R2: A write to byte address 0x000 updates output pins 0..15. Write-data bit 16+i is a protect mask for pin i (1 keeps the old value, 0 loads write-data bit i).
- R3: A write to byte address 0x004 applies the same rule to pins 16..31. Bit 16+i protects pin 16+i, and bit i supplies its new value.
- R4: A masked write to one half never changes output pins in the other half.
- R5: Reads of addresses 0x000 and 0x004 return zero.
- R6: Reading address 0x060 returns the pin inputs, one bit per pin, through a two-flop synchronizer. A level applied before a rising edge is still invisible after that edge and appears after the second one.
- R7: The direction register at 0x204 and the output-enable register at 0x208 are written whole and read back the written value. A direction bit of 1 marks an output.
- R8: `pin_oe[i]` is 1 exactly when direction bit i and output-enable bit i are both 1.
- R9: Writes to the pin-state address 0x060 change neither the latch, the direction or enable registers, nor the value read back there.
- R10: Any other address, including non-word-aligned ones, reads zero, and writes to it have no effect on any register.
- R11: `pin_out` always shows the output latch, whatever the direction and enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels from the pads |
| pin_out | output | NUM_PINS | Output latch to the pads |
| pin_oe | output | NUM_PINS | Per-pin pad drive enable |

## Verification
The assertions take for granted that the bus holds `reg_addr`, `reg_we` and `reg_wdata` stable around each rising edge, and that reset is released away from a clock edge. The synchronizer check also assumes `pin_in` changes only between edges. The stimulus meets this by driving every bus and pin input on the falling edge and sampling results one time unit later. Reset is released on a falling edge as well, so the reset-value property sees a clean rise of `rst_n`.

// File: rtl/gpmw_pkg.sv
package gpmw_pkg;

   localparam int unsigned BUS_W  = 32;
   localparam int unsigned HALF_W = 16;

   // byte offsets of the bank registers
   localparam int unsigned OFF_MW_LO = 'h000;
   localparam int unsigned OFF_MW_HI = 'h004;
   localparam int unsigned OFF_PINS  = 'h060;
   localparam int unsigned OFF_DIR   = 'h204;
   localparam int unsigned OFF_OE    = 'h208;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MW_LO,
      SEL_MW_HI,
      SEL_PINS,
      SEL_DIR,
      SEL_OE
   } reg_sel_e;

endpackage

// File: rtl/gpmw_in_sync.sv
module gpmw_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpmw_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[s] <= '0;
         end else if (s == 0) begin
            stg[s] <= pin_i;
         end else begin
            stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = stg[STAGES-1];

   // latency check for the standard two-stage variant
   if (STAGES == 2) begin : g_chk2
      logic [1:0] age_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            age_q <= '0;
         else if (age_q != 2'd3) age_q <= age_q + 2'd1;
      end
      AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 2'd2) |-> (sync_o == $past(pin_i, 2))); // R6
   end

endmodule

// File: rtl/gpmw_masked_half.sv
module gpmw_masked_half #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] keep_i,
   output logic [W-1:0] q_o
);

   if (W < 1 || W > gpmw_pkg::HALF_W) begin : g_bad_w
      $error("gpmw_masked_half: W must be 1..16");
   end

   logic [W-1:0] q_d;

   always_comb begin
      q_d = q_o;
      if (we_i) begin
         q_d = (q_o & keep_i) | (data_i & ~keep_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= q_d;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q_o == '0)); // R1
   AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (((q_o ^ $past(q_o)) & $past(keep_i)) == '0)); // R2
   AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> ((q_o & ~$past(keep_i)) == ($past(data_i) & ~$past(keep_i)))); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o)); // R4

endmodule

// File: rtl/gpmw_cfg_reg.sv
module gpmw_cfg_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (q_o == $past(d_i))); // R7
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o)); // R10

endmodule

// File: rtl/gpmw_rd_mux.sv
module gpmw_rd_mux
   import gpmw_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  reg_sel_e            sel_i,
   input  logic [NUM_PINS-1:0] pins_i,
   input  logic [NUM_PINS-1:0] dir_i,
   input  logic [NUM_PINS-1:0] oe_i,
   output logic [BUS_W-1:0]    rdata_o
);

   always_comb begin
      rdata_o = '0;
      unique case (sel_i)
         SEL_PINS: rdata_o[NUM_PINS-1:0] = pins_i;
         SEL_DIR:  rdata_o[NUM_PINS-1:0] = dir_i;
         SEL_OE:   rdata_o[NUM_PINS-1:0] = oe_i;
         default:  rdata_o = '0;
      endcase
   end

   AST_MW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel_i == SEL_MW_LO) || (sel_i == SEL_MW_HI)) |-> (rdata_o == '0)); // R5
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_NONE) |-> (rdata_o == '0)); // R10

endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
   import gpmw_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic                reg_we,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);

   localparam int unsigned NHALF = (NUM_PINS + HALF_W - 1) / HALF_W;

   if (NUM_PINS < 1 || NUM_PINS > BUS_W) begin : g_bad_pins
      $error("gpio_mask_bank: NUM_PINS must be 1..32");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("gpio_mask_bank: ADDR_W too small for the register map");
   end

   // ---------------- address decode ----------------
   reg_sel_e sel;

   always_comb begin
      if      (reg_addr == ADDR_W'(OFF_MW_LO)) sel = SEL_MW_LO;
      else if (reg_addr == ADDR_W'(OFF_MW_HI)) sel = SEL_MW_HI;
      else if (reg_addr == ADDR_W'(OFF_PINS))  sel = SEL_PINS;
      else if (reg_addr == ADDR_W'(OFF_DIR))   sel = SEL_DIR;
      else if (reg_addr == ADDR_W'(OFF_OE))    sel = SEL_OE;
      else                                     sel = SEL_NONE;
   end

   logic [1:0] mw_we;
   logic       dir_we;
   logic       oe_we;

   assign mw_we[0] = reg_we && (sel == SEL_MW_LO);
   assign mw_we[1] = reg_we && (sel == SEL_MW_HI);
   assign dir_we   = reg_we && (sel == SEL_DIR);
   assign oe_we    = reg_we && (sel == SEL_OE);

   // ---------------- output latch, one masked half per 16 pins ----------------
   for (genvar h = 0; h < NHALF; h++) begin : g_half
      localparam int unsigned HW = ((NUM_PINS - h*HALF_W) > HALF_W) ?
                                   HALF_W : (NUM_PINS - h*HALF_W);
      gpmw_masked_half #(.W(HW)) u_half (
         .clk    (clk),
         .rst_n  (rst_n),
         .we_i   (mw_we[h]),
         .data_i (reg_wdata[HW-1:0]),
         .keep_i (reg_wdata[HALF_W +: HW]),
         .q_o    (pin_out[h*HALF_W +: HW])
      );
   end

   if (NHALF < 2) begin : g_no_hi
      logic unused_hi_we;
      assign unused_hi_we = mw_we[1];
   end

   // ---------------- direction and enable ----------------
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] oe_q;

   gpmw_cfg_reg #(.W(NUM_PINS)) u_dir (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (dir_we),
      .d_i   (reg_wdata[NUM_PINS-1:0]),
      .q_o   (dir_q)
   );

   gpmw_cfg_reg #(.W(NUM_PINS)) u_oe (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (oe_we),
      .d_i   (reg_wdata[NUM_PINS-1:0]),
      .q_o   (oe_q)
   );

   assign pin_oe = dir_q & oe_q;

   // ---------------- pin readback ----------------
   logic [NUM_PINS-1:0] pins_sync;

   gpmw_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .sync_o (pins_sync)
   );

   gpmw_rd_mux #(.NUM_PINS(NUM_PINS)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (sel),
      .pins_i  (pins_sync),
      .dir_i   (dir_q),
      .oe_i    (oe_q),
      .rdata_o (reg_rdata)
   );

   AST_OE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0)); // R1
   AST_OE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_we || oe_we) |=> (pin_oe == (($past(dir_we) ? $past(reg_wdata[NUM_PINS-1:0]) : $past(dir_q))
                                     & ($past(oe_we)  ? $past(reg_wdata[NUM_PINS-1:0]) : $past(oe_q))))); // R8

endmodule

// File: tb/gpio_mask_bank_tb.sv
module gpio_mask_bank_tb;

   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] reg_addr;
   logic          reg_we;
   logic [31:0]   reg_wdata;
   logic [31:0]   reg_rdata;
   logic [31:0]   pin_in;
   logic [31:0]   pin_out;
   logic [31:0]   pin_oe;

   always #2 clk = ~clk; // 250 MHz

   gpio_mask_bank #(.NUM_PINS(32), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   typedef struct {
      int          kind; // 0 read data, 1 pin_out, 2 pin_oe
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t exp_q[$];
   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;

   // reference state, from the requirements
   logic [31:0] m_out = '0;
   logic [31:0] m_dir = '0;
   logic [31:0] m_oe  = '0;
   logic [31:0] m_pins = '0;

   // ---------------- monitor ----------------
   initial begin
      forever begin
         item_t it;
         logic [31:0] act;
         wait (exp_q.size() != 0);
         it = exp_q.pop_front();
         case (it.kind)
            0:       act = reg_rdata;
            1:       act = pin_out;
            default: act = pin_oe;
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual=%08h expected=%08h", it.tag, act, it.exp);
         end
      end
   end

   // ---------------- driver ----------------
   task automatic push(input int kind, input logic [31:0] exp, input string tag);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.tag  = tag;
      exp_q.push_back(it);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
      reg_addr  = 12'hFFC;
      case (a)
         12'h000: m_out[15:0]  = (m_out[15:0]  & d[31:16]) | (d[15:0] & ~d[31:16]);
         12'h004: m_out[31:16] = (m_out[31:16] & d[31:16]) | (d[15:0] & ~d[31:16]);
         12'h204: m_dir = d;
         12'h208: m_oe  = d;
         default: ;
      endcase
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      push(0, exp, tag);
   endtask

   task automatic chk_pins(input string tag);
      #1;
      push(1, m_out, {tag, " pin_out"});
      push(2, m_dir & m_oe, {tag, " pin_oe"});
   endtask

   task automatic chk_all(input string tag);
      chk_pins(tag);
      rd(12'h204, m_dir, {tag, " dir"});
      rd(12'h208, m_oe, {tag, " oe"});
      rd(12'h060, m_pins, {tag, " pins"});
   endtask

   task automatic pin_step(input logic [31:0] v);
      @(negedge clk);
      pin_in   = v;
      reg_addr = 12'h060;
      #1 push(0, m_pins, "R6 not visible at change");
      @(negedge clk);
      #1 push(0, m_pins, "R6 not visible after one edge");
      @(negedge clk);
      m_pins = v;
      #1 push(0, m_pins, "R6 visible after two edges");
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 50000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      rst_n     = 1'b0;
      reg_addr  = '0;
      reg_we    = 1'b0;
      reg_wdata = '0;
      pin_in    = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_all("R1 reset");

      // R2 low half
      wr(12'h000, 32'h0000_A5C3);
      chk_pins("R2 full low write");
      wr(12'h000, 32'hFF00_0F0F);
      chk_pins("R2 partial mask low byte");
      wr(12'h000, 32'hFFFF_0000);
      chk_pins("R2 all protected");

      // R3 high half, R4 isolation
      wr(12'h004, 32'h0000_1234);
      chk_pins("R3 R4 full high write");
      wr(12'h004, 32'hFFFE_0001);
      chk_pins("R3 single bit 16");
      wr(12'h000, 32'h7FFF_0000);
      chk_pins("R2 R4 clear bit 15 only");

      // R5 masked ports read zero
      rd(12'h000, 32'h0, "R5 low port read");
      rd(12'h004, 32'h0, "R5 high port read");

      // R7 R8 R11 direction and enable
      wr(12'h204, 32'hFF00_FF00);
      chk_all("R7 R8 dir only");
      wr(12'h208, 32'h0FF0_0FF0);
      chk_all("R7 R8 R11 dir and oe");
      wr(12'h004, 32'h0000_FFFF);
      chk_pins("R11 latch independent of enable");

      // R6 synchronizer latency
      pin_step(32'h5A5A_1234);
      pin_step(32'hFFFF_0001);

      // R9 read-only pin register
      wr(12'h060, 32'h0000_0000);
      chk_all("R9 write to pin register");

      // R10 unmapped and misaligned
      wr(12'h100, 32'hFFFF_FFFF);
      wr(12'h202, 32'hFFFF_FFFF);
      wr(12'h001, 32'h0000_FFFF);
      chk_all("R10 writes ignored");
      rd(12'h100, 32'h0, "R10 unmapped read");
      rd(12'h206, 32'h0, "R10 misaligned read");

      wait (exp_q.size() == 0);
      #1;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule